// File: doc/BRIEF.md
# Non-Volatile Word Program Sequencer

This block controls an on-chip non-volatile word array. It has two ports. A small register port carries the control and status registers. A separate 32-bit data window maps the words of the array by byte address, with a 4-byte stride. Software sets a clock divider that derives a slow programming tick from the bus clock, wakes the array, and selects automatic word programming. After that, a single write into the data window starts a complete erase/program cycle with no further command. When the cycle ends, a sticky end-of-program flag is raised, and software clears it with a write-one-to-clear register.

The array is modelled as internal storage. All analog timing is reduced to counts of programming ticks: a wake-up delay after leaving power-down, and a program duration per word. A scale parameter divides both counts, so the same logic runs with short timing in test. Data reads and register reads are combinational from the addressed location.

Top module: `nvm_prog_ctrl`

## Requirements
- R1: After reset, status (0xFE0) reads 0, the divider (0x014) reads 0, the auto-program register (0x00C) reads 0, the power-down register (0x018) reads 1, and data-window reads return 0.
- R2: Register offsets are auto-program 0x00C (bit 0 only), divider 0x014 (low DIV_W bits), power-down 0x018 (bit 0), status 0xFE0 (read-only: bit 0 busy, bit 1 array ready, bit 2 end-of-program), and clear 0xFE8 (reads 0). Any other offset reads 0.
- R3: A programming tick occurs every divider+1 bus cycles. A program cycle lasts PROG_TICKS ticks. Busy therefore stays high for between (PROG_TICKS-1)(div+1)+1 and PROG_TICKS(div+1) cycles, and for exactly PROG_TICKS cycles when the divider is 0.
- R4: Writing 0 to power-down while the array is powered down starts a wake-up delay of WAKE_TICKS ticks. During that delay the ready bit is 0 and data writes are dropped.
- R5: When auto-program is 1 and the array is ready and idle, a data-window write starts a program cycle, and the busy bit is set from the next cycle.
- R6: Data-window writes made while busy are ignored. This holds both for the word being programmed and for other words.
- R7: Until its cycle completes, the word being programmed reads back its old value. After completion, it reads the new value.
- R8: The end-of-program bit (status bit 2) is set when a cycle completes and stays set. Only a write to 0xFE8 with bit 2 set clears it; a write of 0 there has no effect.
- R9: While auto-program is 0, data-window writes are ignored.
- R10: While powered down, data reads return 0 and data writes are dropped. Stored words are retained and read back after waking.
- R11: The data window selects a word with address bits above bit 1; address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_en | input | 1 | Register port access strobe |
| reg_we | input | 1 | Register port write enable |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_en | input | 1 | Data window access strobe |
| mem_we | input | 1 | Data window write enable |
| mem_addr | input | ADDR_W | Data window byte address |
| mem_wdata | input | 32 | Word to program |
| mem_rdata | output | 32 | Word read from the array, or 0 when the array is not ready |

## Verification
The bench measures how long busy stays high with a divider of 1, and again with a divider of 0. An off-by-one in the minus-one divider encoding or in the tick count would push the duration outside the window. It writes to the data window during the wake-up delay, while busy, while powered down, and with auto-program off. A design that leaked any of these writes would show a changed word or a busy bit. It reads the word that is being programmed mid-cycle, which catches a design that commits early. It also writes 0 and then 4 to the clear register, which catches a design whose flag is not sticky or clears on the wrong bit.

// File: rtl/nvm_prog_pkg.sv
package nvm_prog_pkg;

    localparam int BUS_W  = 32;
    localparam int REG_AW = 12;

    localparam logic [REG_AW-1:0] OFS_AUTO = 12'h00C;
    localparam logic [REG_AW-1:0] OFS_DIV  = 12'h014;
    localparam logic [REG_AW-1:0] OFS_PWR  = 12'h018;
    localparam logic [REG_AW-1:0] OFS_STAT = 12'hFE0;
    localparam logic [REG_AW-1:0] OFS_SCLR = 12'hFE8;

    localparam int EOP_BIT = 2;

    // status word layout: bit2 eop, bit1 ready, bit0 busy
    typedef struct packed {
        logic eop;
        logic ready;
        logic busy;
    } stat_t;

    typedef enum logic [1:0] {
        PWR_OFF  = 2'd0,
        PWR_WAKE = 2'd1,
        PWR_ON   = 2'd2
    } pwr_state_t;

    function automatic int scaled_count(input int base, input int scale);
        int r;
        r = base / scale;
        return (r < 1) ? 1 : r;
    endfunction

    function automatic logic [BUS_W-1:0] pack_status(input stat_t s);
        return {{(BUS_W-3){1'b0}}, s};
    endfunction

endpackage

// File: rtl/nvm_tick_gen.sv
module nvm_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // one tick every div+1 cycles
    assign tick = (cnt >= div);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/nvm_pwr_ctrl.sv
module nvm_pwr_ctrl
    import nvm_prog_pkg::*;
#(
    parameter int WAKE_TICKS = 150
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       wr_down,
    input  logic       tick,
    output pwr_state_t state,
    output logic       ready
);
    localparam int CW = $clog2(WAKE_TICKS + 1);

    logic [CW-1:0] cnt;

    assign ready = (state == PWR_ON);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PWR_OFF;
            cnt   <= '0;
        end else if (wr_en && wr_down) begin
            state <= PWR_OFF;
            cnt   <= '0;
        end else if (wr_en && !wr_down && state == PWR_OFF) begin
            state <= PWR_WAKE;
            cnt   <= CW'(WAKE_TICKS);
        end else if (state == PWR_WAKE && tick) begin
            if (cnt <= 1) begin
                state <= PWR_ON;
                cnt   <= '0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/nvm_prog_seq.sv
module nvm_prog_seq #(
    parameter int PROG_TICKS = 4500,
    parameter int IDX_W      = 8,
    parameter int DATA_W     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [IDX_W-1:0]  start_idx,
    input  logic [DATA_W-1:0] start_data,
    input  logic              tick,
    output logic              busy,
    output logic              commit,
    output logic [IDX_W-1:0]  commit_idx,
    output logic [DATA_W-1:0] commit_data
);
    localparam int CW = $clog2(PROG_TICKS + 1);

    logic [CW-1:0]     cnt;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] data_q;

    assign commit      = busy && tick && (cnt <= 1);
    assign commit_idx  = idx_q;
    assign commit_data = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cnt    <= '0;
            idx_q  <= '0;
            data_q <= '0;
        end else if (!busy && start) begin
            busy   <= 1'b1;
            cnt    <= CW'(PROG_TICKS);
            idx_q  <= start_idx;
            data_q <= start_data;
        end else if (busy && tick) begin
            if (cnt <= 1) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/nvm_word_array.sv
module nvm_word_array #(
    parameter int WORDS  = 256,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] words [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words[g] <= '0;
            end else if (we && widx == IDX_W'(g)) begin
                words[g] <= wdata;
            end
        end
    end

    assign rdata = words[ridx];
endmodule

// File: rtl/nvm_prog_ctrl.sv
module nvm_prog_ctrl
    import nvm_prog_pkg::*;
#(
    parameter int WORDS     = 256,
    parameter int DIV_W     = 8,
    parameter int PROG_BASE = 4500,
    parameter int WAKE_BASE = 150,
    parameter int TIME_DIV  = 1,
    parameter int ADDR_W    = $clog2(WORDS * 4)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              mem_en,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [31:0]       mem_wdata,
    output logic [31:0]       mem_rdata
);
    localparam int PROG_TICKS = scaled_count(PROG_BASE, TIME_DIV);
    localparam int WAKE_TICKS = scaled_count(WAKE_BASE, TIME_DIV);
    localparam int IDX_W      = ADDR_W - 2;

    logic             auto_q;
    logic [DIV_W-1:0] div_q;
    logic             eop_q;
    logic             tick;
    logic             ready;
    logic             busy;
    logic             commit;
    logic [IDX_W-1:0] commit_idx;
    logic [31:0]      commit_data;
    logic [31:0]      arr_rdata;
    pwr_state_t       pwr_state;
    stat_t            stat;

    logic reg_wr, pwr_wr, clr_hit, start;
    logic unused_bits;

    assign reg_wr  = reg_en && reg_we;
    assign pwr_wr  = reg_wr && (reg_addr == OFS_PWR);
    assign clr_hit = reg_wr && (reg_addr == OFS_SCLR) && reg_wdata[EOP_BIT];
    assign start   = mem_en && mem_we && auto_q && ready && !busy;

    assign unused_bits = ^{mem_addr[1:0], reg_wdata[31:DIV_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            auto_q <= 1'b0;
            div_q  <= '0;
        end else if (reg_wr) begin
            if (reg_addr == OFS_AUTO) auto_q <= reg_wdata[0];
            if (reg_addr == OFS_DIV)  div_q  <= reg_wdata[DIV_W-1:0];
        end
    end

    // completion outranks a simultaneous clear
    always_ff @(posedge clk) begin
        if (rst) begin
            eop_q <= 1'b0;
        end else if (commit) begin
            eop_q <= 1'b1;
        end else if (clr_hit) begin
            eop_q <= 1'b0;
        end
    end

    nvm_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .div  (div_q),
        .tick (tick)
    );

    nvm_pwr_ctrl #(.WAKE_TICKS(WAKE_TICKS)) u_pwr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (pwr_wr),
        .wr_down (reg_wdata[0]),
        .tick    (tick),
        .state   (pwr_state),
        .ready   (ready)
    );

    nvm_prog_seq #(
        .PROG_TICKS (PROG_TICKS),
        .IDX_W      (IDX_W),
        .DATA_W     (32)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .start_idx   (mem_addr[ADDR_W-1:2]),
        .start_data  (mem_wdata),
        .tick        (tick),
        .busy        (busy),
        .commit      (commit),
        .commit_idx  (commit_idx),
        .commit_data (commit_data)
    );

    nvm_word_array #(
        .WORDS  (WORDS),
        .DATA_W (32),
        .IDX_W  (IDX_W)
    ) u_arr (
        .clk   (clk),
        .rst   (rst),
        .we    (commit),
        .widx  (commit_idx),
        .wdata (commit_data),
        .ridx  (mem_addr[ADDR_W-1:2]),
        .rdata (arr_rdata)
    );

    assign mem_rdata = ready ? arr_rdata : '0;

    assign stat = '{eop: eop_q, ready: ready, busy: busy};

    always_comb begin
        case (reg_addr)
            OFS_AUTO: reg_rdata = {31'b0, auto_q};
            OFS_DIV:  reg_rdata = {{(32-DIV_W){1'b0}}, div_q};
            OFS_PWR:  reg_rdata = {31'b0, pwr_state == PWR_OFF};
            OFS_STAT: reg_rdata = pack_status(stat);
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/nvm_prog_ctrl_chk.sv
module nvm_prog_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        ready,
    input logic        eop,
    input logic        clr_hit,
    input logic        tick,
    input logic [31:0] mem_rdata
);
    AST_EOP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (eop && !clr_hit) |=> eop);                                  // R8
    AST_EOP_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> eop);                                        // R8
    AST_RDATA_GATED: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (mem_rdata == 32'h0));                            // R10
    AST_NO_START_UNREADY: assert property (@(posedge clk) disable iff (rst)
        (!ready && !busy) |=> !busy);                                // R4
    AST_BUSY_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick) |=> busy);                                   // R3
endmodule

bind nvm_prog_ctrl nvm_prog_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .ready     (ready),
    .eop       (eop_q),
    .clr_hit   (clr_hit),
    .tick      (tick),
    .mem_rdata (mem_rdata)
);

// File: tb/nvm_prog_ctrl_tb.sv
`timescale 1ns/1ps
module nvm_prog_ctrl_tb;
    localparam int AW   = 6;
    localparam int PT   = 90;
    localparam logic [11:0] A_AUTO = 12'h00C;
    localparam logic [11:0] A_DIV  = 12'h014;
    localparam logic [11:0] A_PWR  = 12'h018;
    localparam logic [11:0] A_STAT = 12'hFE0;
    localparam logic [11:0] A_CLR  = 12'hFE8;

    typedef struct packed {
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VECS [0:6] = '{
        '{12'h00C, 32'h0000_0005, 32'h1},
        '{12'h014, 32'h0000_01FF, 32'hFF},
        '{12'h014, 32'h0000_0003, 32'h3},
        '{12'h018, 32'h0000_0001, 32'h1},
        '{12'h100, 32'h0000_FFFF, 32'h0},
        '{12'hFE0, 32'h0000_0007, 32'h0},
        '{12'hFE8, 32'h0000_0004, 32'h0}
    };

    logic          clk = 0;
    logic          rst = 1;
    logic          reg_en = 0, reg_we = 0;
    logic [11:0]   reg_addr = '0;
    logic [31:0]   reg_wdata = '0, reg_rdata;
    logic          mem_en = 0, mem_we = 0;
    logic [AW-1:0] mem_addr = '0;
    logic [31:0]   mem_wdata = '0, mem_rdata;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    nvm_prog_ctrl #(.WORDS(16), .DIV_W(8), .TIME_DIV(50)) u_dut (
        .clk(clk), .rst(rst),
        .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 0; reg_we = 0;
    endtask

    task automatic reg_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic mem_wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        mem_en = 1; mem_we = 1; mem_addr = a; mem_wdata = d;
        @(negedge clk);
        mem_en = 0; mem_we = 0;
    endtask

    task automatic mem_rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        mem_en = 1; mem_we = 0; mem_addr = a;
        #1 d = mem_rdata;
        mem_en = 0;
    endtask

    // counts cycles with busy high, starting at the current negedge
    task automatic busy_len(output int n);
        n = 0;
        reg_addr = A_STAT;
        #1;
        while (reg_rdata[0] && n < 1000) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wait_ready();
        logic [31:0] s;
        for (int i = 0; i < 50; i++) begin
            reg_rd(A_STAT, s);
            if (s[1]) break;
        end
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 500; i++) begin
            reg_rd(A_STAT, s);
            if (!s[0]) break;
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        reg_rd(A_STAT, v); chk("R1 status", v, 32'h0);
        reg_rd(A_DIV, v);  chk("R1 divider", v, 32'h0);
        reg_rd(A_AUTO, v); chk("R1 auto", v, 32'h0);
        reg_rd(A_PWR, v);  chk("R1 powerdown", v, 32'h1);
        mem_rd(6'h08, v);  chk("R1 data read", v, 32'h0);

        // R2 register map via vector table
        for (int i = 0; i < 7; i++) begin
            reg_wr(VECS[i].addr, VECS[i].wdata);
            reg_rd(VECS[i].addr, v);
            chk($sformatf("R2 vec %0d", i), v, VECS[i].exp);
        end

        reg_wr(A_DIV, 32'h1);
        reg_wr(A_AUTO, 32'h1);
        mem_wr(6'h04, 32'h11);            // dropped while down (R10)

        // R4 wake-up delay
        reg_wr(A_PWR, 32'h0);
        reg_rd(A_STAT, v); chk("R4 not ready during wake", {31'b0, v[1]}, 32'h0);
        mem_wr(6'h04, 32'h22);
        wait_ready();
        reg_rd(A_STAT, v); chk("R4 write dropped (busy)", {31'b0, v[0]}, 32'h0);
        mem_rd(6'h04, v);  chk("R4 word untouched", v, 32'h0);

        // R3 duration with divider 1
        mem_wr(6'h08, 32'hA5A5_0001);
        busy_len(n);
        chk_rng("R3 busy length div1", n, (PT-1)*2+1, PT*2);
        reg_rd(A_STAT, v); chk("R8 eop set", {31'b0, v[2]}, 32'h1);
        mem_rd(6'h08, v);  chk("R7 new value", v, 32'hA5A5_0001);

        // R5 R6 R7 second cycle
        mem_wr(6'h08, 32'h0BAD_F00D);
        reg_rd(A_STAT, v); chk("R5 busy set", {31'b0, v[0]}, 32'h1);
        mem_rd(6'h08, v);  chk("R7 old value mid-cycle", v, 32'hA5A5_0001);
        mem_wr(6'h08, 32'hDEAD_0000);
        mem_wr(6'h0C, 32'hBEEF_0000);
        wait_idle();
        mem_rd(6'h08, v);  chk("R6 same word kept", v, 32'h0BAD_F00D);
        mem_rd(6'h0C, v);  chk("R6 other word untouched", v, 32'h0);
        reg_rd(A_STAT, v); chk("R8 eop sticky", {31'b0, v[2]}, 32'h1);

        // R8 clear
        reg_wr(A_CLR, 32'h0);
        reg_rd(A_STAT, v); chk("R8 zero write no clear", {31'b0, v[2]}, 32'h1);
        reg_wr(A_CLR, 32'h4);
        reg_rd(A_STAT, v); chk("R8 cleared", {31'b0, v[2]}, 32'h0);

        // R3 exact with divider 0, R11 stride
        reg_wr(A_DIV, 32'h0);
        mem_wr(6'h0D, 32'h0000_1234);
        busy_len(n);
        chk_rng("R3 busy length div0", n, PT, PT);
        mem_rd(6'h0C, v);  chk("R11 low bits ignored", v, 32'h0000_1234);
        mem_rd(6'h08, v);  chk("R11 neighbour word", v, 32'h0BAD_F00D);

        // R9 auto-program off
        reg_wr(A_AUTO, 32'h0);
        mem_wr(6'h10, 32'h77);
        reg_rd(A_STAT, v); chk("R9 no busy", {31'b0, v[0]}, 32'h0);
        repeat (5) @(negedge clk);
        mem_rd(6'h10, v);  chk("R9 word untouched", v, 32'h0);

        // R10 powered down
        reg_wr(A_PWR, 32'h1);
        reg_rd(A_STAT, v); chk("R10 not ready", {31'b0, v[1]}, 32'h0);
        mem_rd(6'h08, v);  chk("R10 read zero", v, 32'h0);
        reg_wr(A_AUTO, 32'h1);
        mem_wr(6'h14, 32'h55);
        reg_wr(A_PWR, 32'h0);
        wait_ready();
        reg_rd(A_STAT, v); chk("R10 write dropped", {31'b0, v[0]}, 32'h0);
        mem_rd(6'h14, v);  chk("R10 word untouched", v, 32'h0);
        mem_rd(6'h08, v);  chk("R10 retention", v, 32'h0BAD_F00D);
        mem_rd(6'h04, v);  chk("R10 early write dropped", v, 32'h0);

        finished = 1;
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule